// File: doc/BRIEF.md
# Transport Overhead Serial Insertion Port

This block sits on the transmit side of a SONET line interface and gathers line overhead bytes from an external serial source, one bit per request. It serves two independent channels: a line data-communications channel that delivers nine bytes per frame, and an orderwire channel that delivers three bytes per frame. For each channel it raises a single-cycle request strobe. The source answers on the following falling edge of the overhead clock, and the block samples the bit on the rising edge that ends the request cycle.

The sampled bits are packed most significant bit first into bytes. Each completed byte is presented with a one-cycle valid strobe and its position within the frame, ready for a downstream frame builder to insert.

A frame-start input restarts both channels. Before the first orderwire request of each frame, the orderwire channel emits a one-cycle frame marker, so the source can align its byte sequence. If a new frame starts before every bit of a channel has been requested, a sticky underrun flag is raised.

Top module: `toh_serial_port`

## Requirements
- R1: While reset is asserted and after its release until the first frame start, every output is low: request strobes, frame marker, byte valid strobes, byte values (all zeros), byte indices and underrun flags.
- R2: The first request pulse of a frame appears in the second cycle after the cycle in which frame_start is sampled high. Request pulses then follow every REQ_GAP cycles. There are exactly 8 × (bytes per channel) requests per frame and none after that. Two requests are never in adjacent cycles.
- R3: A serial input is sampled only on the rising clock edge that ends a cycle in which its channel's request is high. Values driven at other times have no effect on the assembled bytes.
- R4: Within each byte the first sampled bit becomes bit 7 and the eighth sampled bit becomes bit 0.
- R5: The byte valid strobe is high for exactly the one cycle after the eighth bit of a byte is sampled. During that cycle the byte index gives the byte's position, counting up from 0 in the order the bytes were gathered.
- R6: The line DCC channel delivers nine bytes per frame, with indices 0 to 8.
- R7: The orderwire channel delivers three bytes per frame, with indices 0 to 2. ow_frame is high for exactly one cycle per frame start: the cycle immediately before the first orderwire request.
- R8: A serial input held low produces bytes that are all zeros.
- R9: A frame start that arrives while a channel still has bits left to request sets that channel's underrun flag. The flag stays high until reset. A frame start after a fully requested frame, or the first frame start after reset, leaves the flag low.
- R10: A frame start discards any partially gathered byte and restarts the byte index. The first byte of the new frame carries index 0 and contains only bits requested after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Overhead clock; sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a new outbound frame |
| dcc_sdi | input | 1 | Serial data for the line DCC channel |
| ow_sdi | input | 1 | Serial data for the orderwire channel |
| dcc_req | output | 1 | Request strobe for the next DCC bit |
| dcc_byte | output | BYTE_W | Last completed DCC byte |
| dcc_byte_vld | output | 1 | One-cycle strobe for a completed DCC byte |
| dcc_byte_idx | output | cnt_w(DCC_BYTES) | Position of the completed DCC byte in the frame |
| dcc_underrun | output | 1 | Sticky flag: a DCC frame was cut short |
| ow_req | output | 1 | Request strobe for the next orderwire bit |
| ow_frame | output | 1 | One-cycle marker before the first orderwire request |
| ow_byte | output | BYTE_W | Last completed orderwire byte |
| ow_byte_vld | output | 1 | One-cycle strobe for a completed orderwire byte |
| ow_byte_idx | output | cnt_w(OW_BYTES) | Position of the completed orderwire byte in the frame |
| ow_underrun | output | 1 | Sticky flag: an orderwire frame was cut short |

## Verification
The bench builds the block with nine DCC bytes, three orderwire bytes and REQ_GAP set to 3. The wider spacing lets the pace counter run through idle cycles between requests. It also gives the source model room to drive the inverse of the expected bit on every falling edge that follows no request, so any sample taken on the wrong edge corrupts a byte. With 72 and 24 requests at that spacing, a complete frame takes about 220 cycles. That is short enough to run several full frames, one all-zero frame and one frame cut off after 20 cycles, which exercises the underrun and restart paths of both channels.

// File: rtl/toh_pkg.sv
package toh_pkg;

  // counter width able to hold 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // serial bits a channel must request in one frame
  function automatic int chan_bits(input int nbytes, input int bw);
    return nbytes * bw;
  endfunction

  // pace counter step: wraps after gap cycles
  function automatic int next_pace(input int pace, input int gap);
    return (pace >= gap - 1) ? 0 : pace + 1;
  endfunction

endpackage

// File: rtl/toh_pacer.sv
module toh_pacer
  import toh_pkg::*;
#(
  parameter int NBYTES = 9,
  parameter int BW     = 8,
  parameter int GAP    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  output logic req,
  output logic underrun
);
  localparam int TOTAL = chan_bits(NBYTES, BW);
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int PW    = cnt_w(GAP);

  logic          active;
  logic [PW-1:0] pace;
  logic [CW-1:0] req_cnt;
  logic          req_q;
  logic          unr_q;

  // named events for the assertions
  wire more_bits   = req_cnt < CW'(TOTAL);
  wire fire        = active && more_bits && (pace == '0) && !frame_start;
  wire short_frame = frame_start && active && more_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pace    <= '0;
      req_cnt <= '0;
      req_q   <= 1'b0;
      unr_q   <= 1'b0;
    end else if (frame_start) begin
      active  <= 1'b1;
      pace    <= '0;
      req_cnt <= '0;
      req_q   <= 1'b0;
      if (short_frame) unr_q <= 1'b1;
    end else begin
      req_q <= fire;
      if (fire) req_cnt <= req_cnt + 1'b1;
      if (active && more_bits) pace <= PW'(next_pace(int'(pace), GAP));
    end
  end

  assign req      = req_q;
  assign underrun = unr_q;

  // R2
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= CW'(TOTAL));

  // R9
  sticky_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unr_q |=> unr_q);

  generate
    if (GAP >= 2) begin : g_spacing
      // R2
      req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);
    end
  endgenerate

endmodule

// File: rtl/toh_assembler.sv
module toh_assembler
  import toh_pkg::*;
#(
  parameter int NBYTES = 9,
  parameter int BW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      take,
  input  logic                      sdi,
  output logic [BW-1:0]             byte_out,
  output logic                      byte_vld,
  output logic [cnt_w(NBYTES)-1:0]  byte_idx
);
  localparam int IW  = cnt_w(NBYTES);
  localparam int BCW = cnt_w(BW);

  logic [BW-1:0]  shreg;
  logic [BCW-1:0] bit_cnt;
  logic [IW-1:0]  next_idx;
  logic [BW-1:0]  byte_q;
  logic           vld_q;
  logic [IW-1:0]  idx_q;

  wire [BW-1:0] shifted   = {shreg[BW-2:0], sdi};
  wire          last_bit  = take && (bit_cnt == BCW'(BW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      next_idx <= '0;
      byte_q   <= '0;
      vld_q    <= 1'b0;
      idx_q    <= '0;
    end else if (frame_start) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      next_idx <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (take) begin
        shreg   <= shifted;
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end
      if (last_bit) begin
        byte_q   <= shifted;
        vld_q    <= 1'b1;
        idx_q    <= next_idx;
        next_idx <= next_idx + 1'b1;
      end
    end
  end

  assign byte_out = byte_q;
  assign byte_vld = vld_q;
  assign byte_idx = idx_q;

  // R5
  vld_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(take));

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (idx_q < IW'(NBYTES)));

endmodule

// File: rtl/toh_chan.sv
module toh_chan
  import toh_pkg::*;
#(
  parameter int NBYTES = 9,
  parameter int BW     = 8,
  parameter int GAP    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      sdi,
  output logic                      req,
  output logic [BW-1:0]             byte_out,
  output logic                      byte_vld,
  output logic [cnt_w(NBYTES)-1:0]  byte_idx,
  output logic                      underrun
);
  logic req_w;

  toh_pacer #(.NBYTES(NBYTES), .BW(BW), .GAP(GAP)) i_pacer (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .req         (req_w),
    .underrun    (underrun)
  );

  toh_assembler #(.NBYTES(NBYTES), .BW(BW)) i_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .take        (req_w),
    .sdi         (sdi),
    .byte_out    (byte_out),
    .byte_vld    (byte_vld),
    .byte_idx    (byte_idx)
  );

  assign req = req_w;

  // R3
  no_req_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !req_w);

endmodule

// File: rtl/toh_serial_port.sv
module toh_serial_port
  import toh_pkg::*;
#(
  parameter int DCC_BYTES = 9,
  parameter int OW_BYTES  = 3,
  parameter int BYTE_W    = 8,
  parameter int REQ_GAP   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_start,
  input  logic                         dcc_sdi,
  input  logic                         ow_sdi,
  output logic                         dcc_req,
  output logic [BYTE_W-1:0]            dcc_byte,
  output logic                         dcc_byte_vld,
  output logic [cnt_w(DCC_BYTES)-1:0]  dcc_byte_idx,
  output logic                         dcc_underrun,
  output logic                         ow_req,
  output logic                         ow_frame,
  output logic [BYTE_W-1:0]            ow_byte,
  output logic                         ow_byte_vld,
  output logic [cnt_w(OW_BYTES)-1:0]   ow_byte_idx,
  output logic                         ow_underrun
);
  logic frame_q;

  toh_chan #(.NBYTES(DCC_BYTES), .BW(BYTE_W), .GAP(REQ_GAP)) i_dcc (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sdi         (dcc_sdi),
    .req         (dcc_req),
    .byte_out    (dcc_byte),
    .byte_vld    (dcc_byte_vld),
    .byte_idx    (dcc_byte_idx),
    .underrun    (dcc_underrun)
  );

  toh_chan #(.NBYTES(OW_BYTES), .BW(BYTE_W), .GAP(REQ_GAP)) i_ow (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sdi         (ow_sdi),
    .req         (ow_req),
    .byte_out    (ow_byte),
    .byte_vld    (ow_byte_vld),
    .byte_idx    (ow_byte_idx),
    .underrun    (ow_underrun)
  );

  // marker one cycle ahead of the first orderwire request
  always_ff @(posedge clk) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= frame_start;
  end

  assign ow_frame = frame_q;

  // R7
  frame_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |=> ow_req);

  // R7
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |=> !frame_q);

endmodule

// File: tb/test_toh_serial_port.sv
module test_toh_serial_port;
  localparam int GAP       = 3;
  localparam int DCC_N     = 9;
  localparam int OW_N      = 3;
  localparam int DCC_BITS  = DCC_N * 8;
  localparam int OW_BITS   = OW_N * 8;
  localparam int FRAME_CYC = 2 + DCC_BITS * GAP + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic dcc_sdi = 1'b0;
  logic ow_sdi = 1'b0;
  logic dcc_req, dcc_byte_vld, dcc_underrun;
  logic ow_req, ow_frame, ow_byte_vld, ow_underrun;
  logic [7:0] dcc_byte, ow_byte;
  logic [3:0] dcc_byte_idx;
  logic [1:0] ow_byte_idx;

  always #5 clk = ~clk;

  toh_serial_port #(.DCC_BYTES(DCC_N), .OW_BYTES(OW_N), .BYTE_W(8), .REQ_GAP(GAP))
  i_toh_serial_port (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .dcc_sdi(dcc_sdi), .ow_sdi(ow_sdi),
    .dcc_req(dcc_req), .dcc_byte(dcc_byte), .dcc_byte_vld(dcc_byte_vld),
    .dcc_byte_idx(dcc_byte_idx), .dcc_underrun(dcc_underrun),
    .ow_req(ow_req), .ow_frame(ow_frame), .ow_byte(ow_byte),
    .ow_byte_vld(ow_byte_vld), .ow_byte_idx(ow_byte_idx), .ow_underrun(ow_underrun)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // expected byte values of a frame
  logic [7:0] seed = 8'h00;
  bit quiet = 1'b0;
  function automatic logic [7:0] dcc_exp(input logic [7:0] s, input int i);
    return s ^ (8'(i) * 8'h1D + 8'h35);
  endfunction
  function automatic logic [7:0] ow_exp(input logic [7:0] s, input int i);
    return ~s ^ (8'(i) * 8'h47 + 8'hC2);
  endfunction

  // source model: answers each request on the falling edge, else drives junk
  int dcc_ptr = 0;
  int ow_ptr = 0;
  function automatic logic dcc_bit(input int p);
    logic [7:0] b;
    if (p >= DCC_BITS) return 1'b0;
    b = dcc_exp(seed, p / 8);
    return b[7 - (p % 8)];
  endfunction
  function automatic logic ow_bit(input int p);
    logic [7:0] b;
    if (p >= OW_BITS) return 1'b0;
    b = ow_exp(seed, p / 8);
    return b[7 - (p % 8)];
  endfunction

  always @(negedge clk) begin
    if (dcc_req) begin
      dcc_sdi <= quiet ? 1'b0 : dcc_bit(dcc_ptr);
      dcc_ptr <= dcc_ptr + 1;
    end else begin
      dcc_sdi <= quiet ? 1'b0 : ~dcc_bit(dcc_ptr);
    end
    if (ow_req) begin
      ow_sdi <= quiet ? 1'b0 : ow_bit(ow_ptr);
      ow_ptr <= ow_ptr + 1;
    end else begin
      ow_sdi <= quiet ? 1'b0 : ~ow_bit(ow_ptr);
    end
  end

  // monitor
  int ncyc = 0;
  int dcc_reqs, ow_reqs, gap_viol, frame_cnt, frame_cyc;
  int dcc_first, ow_first, dcc_last_req, ow_last_req, dcc_last_vld;
  int dcc_nb, ow_nb, ord_err;
  logic [7:0] dcc_got [DCC_N];
  logic [7:0] ow_got [OW_N];

  task automatic clear_mon();
    dcc_reqs = 0; ow_reqs = 0; gap_viol = 0; frame_cnt = 0; frame_cyc = -100;
    dcc_first = -1; ow_first = -1; dcc_last_req = -100; ow_last_req = -100;
    dcc_last_vld = -1; dcc_nb = 0; ow_nb = 0; ord_err = 0;
    for (int i = 0; i < DCC_N; i++) dcc_got[i] = 8'hxx;
    for (int i = 0; i < OW_N; i++) ow_got[i] = 8'hxx;
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (ow_frame) begin frame_cnt++; frame_cyc = ncyc; end
    if (dcc_req) begin
      if (dcc_reqs == 0) dcc_first = ncyc;
      else if (ncyc - dcc_last_req != GAP) gap_viol++;
      dcc_last_req = ncyc; dcc_reqs++;
    end
    if (ow_req) begin
      if (ow_reqs == 0) ow_first = ncyc;
      else if (ncyc - ow_last_req != GAP) gap_viol++;
      ow_last_req = ncyc; ow_reqs++;
    end
    if (dcc_byte_vld) begin
      if (int'(dcc_byte_idx) != dcc_nb || dcc_nb >= DCC_N) ord_err++;
      else dcc_got[dcc_nb] = dcc_byte;
      dcc_nb++; dcc_last_vld = ncyc;
    end
    if (ow_byte_vld) begin
      if (int'(ow_byte_idx) != ow_nb || ow_nb >= OW_N) ord_err++;
      else ow_got[ow_nb] = ow_byte;
      ow_nb++;
    end
  end

  task automatic start_frame(input logic [7:0] s, input bit q);
    @(negedge clk) frame_start = 1'b1;
    @(posedge clk);
    #1;
    seed = s; quiet = q; dcc_ptr = 0; ow_ptr = 0;
    clear_mon();
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic check_frame(input string tag);
    check(dcc_reqs == DCC_BITS, "R2 dcc request count", dcc_reqs, DCC_BITS);
    check(ow_reqs == OW_BITS, "R2 ow request count", ow_reqs, OW_BITS);
    check(gap_viol == 0, "R2 request spacing", gap_viol, 0);
    check(dcc_first == frame_cyc + 1, "R2 first dcc request timing", dcc_first, frame_cyc + 1);
    check(ow_first == frame_cyc + 1, "R7 frame marker precedes ow request", ow_first, frame_cyc + 1);
    check(frame_cnt == 1, "R7 one frame marker", frame_cnt, 1);
    check(dcc_last_vld == dcc_last_req + 1, "R5 valid after eighth bit", dcc_last_vld, dcc_last_req + 1);
    check(ord_err == 0, "R5 byte index order", ord_err, 0);
    check(dcc_nb == DCC_N, "R6 dcc byte count", dcc_nb, DCC_N);
    check(ow_nb == OW_N, "R7 ow byte count", ow_nb, OW_N);
    for (int i = 0; i < DCC_N; i++) begin
      logic [7:0] e;
      e = quiet ? 8'h00 : dcc_exp(seed, i);
      check(dcc_got[i] === e, {tag, " dcc byte (R3 R4)"}, int'(dcc_got[i]), int'(e));
    end
    for (int i = 0; i < OW_N; i++) begin
      logic [7:0] e;
      e = quiet ? 8'h00 : ow_exp(seed, i);
      check(ow_got[i] === e, {tag, " ow byte (R3 R4)"}, int'(ow_got[i]), int'(e));
    end
  endtask

  task automatic t_reset();
    clear_mon();
    repeat (3) @(negedge clk);
    check(!dcc_req && !ow_req && !ow_frame, "R1 strobes low in reset", {dcc_req, ow_req, ow_frame}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({dcc_req, ow_req, ow_frame, dcc_byte_vld, ow_byte_vld} == 5'b0, "R1 strobes low", 1, 0);
    check(dcc_byte == 8'h00 && ow_byte == 8'h00, "R1 bytes zero", {dcc_byte, ow_byte}, 0);
    check(dcc_byte_idx == 0 && ow_byte_idx == 0, "R1 indices zero", {dcc_byte_idx, ow_byte_idx}, 0);
    check(!dcc_underrun && !ow_underrun, "R1 underrun low", {dcc_underrun, ow_underrun}, 0);
  endtask

  task automatic t_full_frames();
    start_frame(8'h5A, 1'b0);
    repeat (FRAME_CYC) @(negedge clk);
    check_frame("R6 R7 frame A");
    start_frame(8'hC3, 1'b0);
    check(!dcc_underrun && !ow_underrun, "R9 no underrun after full frame", {dcc_underrun, ow_underrun}, 0);
    repeat (FRAME_CYC) @(negedge clk);
    check_frame("R6 R7 frame B");
    check(dcc_byte == dcc_exp(8'hC3, DCC_N - 1), "R5 byte held", int'(dcc_byte), int'(dcc_exp(8'hC3, DCC_N - 1)));
  endtask

  task automatic t_quiet();
    start_frame(8'h77, 1'b1);
    repeat (FRAME_CYC) @(negedge clk);
    check_frame("R8 held-low input");
  endtask

  task automatic t_abort();
    start_frame(8'h96, 1'b0);
    repeat (20) @(negedge clk);
    check(!dcc_underrun && !ow_underrun, "R9 no underrun mid-frame", {dcc_underrun, ow_underrun}, 0);
    start_frame(8'h3C, 1'b0);
    check(dcc_underrun && ow_underrun, "R9 underrun on short frame", {dcc_underrun, ow_underrun}, 3);
    repeat (FRAME_CYC) @(negedge clk);
    check_frame("R10 restarted frame");
    start_frame(8'hE1, 1'b0);
    repeat (FRAME_CYC) @(negedge clk);
    check(dcc_underrun && ow_underrun, "R9 underrun sticky", {dcc_underrun, ow_underrun}, 3);
  endtask

  initial begin
    t_reset();
    t_full_frames();
    t_quiet();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule